// File: doc/BRIEF.md
# Inter-Core Send Command Sequencer

This block takes 64-bit command writes aimed at one core's inter-processor register window and turns them into operations on another core's register block. Three command offsets are recognised. A doorbell command asks the destination core to raise one status bit. A slot-post command and a free-address command both deposit a 32-bit word into the destination's registers through a byte-granular read-modify-write.

Every command carries a 10-bit destination core number, which is checked against the number of cores that exist. Posting commands also carry a four-bit byte-keep mask and a 32-bit payload. When no byte is kept, the payload goes straight out as a single write. When at least one byte is kept, the block first fetches the old word over its target bus, blends it with the payload and then writes the result back. A target that reports a failure ends the sequence with an error pulse. A busy flag holds off further commands while a bus sequence is in flight.

Top module: `ipi_send_decoder`

## Requirements
- R1: The destination core is `cmd_data[25:16]`. A value of `NUM_CORES` or more is absent: the block pulses `err` one cycle after acceptance. It raises no `done`, no `bus_req` and no `ipi_set_valid`.
- R2: A command at offset 0x040 to a present core pulses `ipi_set_valid` and `done` together, one cycle after acceptance. `ipi_set_core` carries the core and `ipi_set_vec` carries `cmd_data[4:0]`.
- R3: A command at offset 0x048 targets address 0x1020 + 4 × `cmd_data[4:2]` on the destination core.
- R4: A command at offset 0x158 targets address `cmd_data[15:0]` on the destination core.
- R5: Keep bits `cmd_data[27+i]` (i = 0..3) protect byte i of the destination word. The word written is (old AND keep) OR (payload AND NOT keep), where the payload is `cmd_data[63:32]`.
- R6: With all four keep bits clear, the block issues no read. It writes the payload directly as one write.
- R7: With any keep bit set, the block reads the destination word first. It then writes the merged word to the same core and address.
- R8: `busy` is high from the cycle after a posting command is accepted until its final acknowledge. A command presented while `busy` is high is ignored. `bus_req`, `bus_we` and `bus_addr` stay steady until `bus_ack`.
- R9: An acknowledge that carries `bus_err` aborts the sequence with an `err` pulse instead of `done`. A failed read produces no write.
- R10: A valid command at any other offset produces no response and no bus or doorbell activity.
- R11: After reset, `busy`, `done`, `err`, `bus_req` and `ipi_set_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_offset | input | 9 | Offset of the command within the register window |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | A posting sequence is in flight |
| done | output | 1 | Command completed (one-cycle pulse) |
| err | output | 1 | Command failed (one-cycle pulse) |
| ipi_set_valid | output | 1 | Doorbell strobe to the destination core |
| ipi_set_core | output | 10 | Doorbell destination core |
| ipi_set_vec | output | 5 | Status bit to raise |
| bus_req | output | 1 | Target bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_core | output | 10 | Destination core of the access |
| bus_addr | output | 16 | Register address on the destination core |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Target acknowledge |
| bus_err | input | 1 | Target failure, valid with `bus_ack` |

## Verification
The bench sweeps every keep mask against every mailbox slot and against several free addresses on each present core. A merge with reversed keep polarity or shifted byte lanes would corrupt the stored word. A design that reads with a clear mask would show an extra read in the bench's read count. The bench also targets the first absent core and the largest core number; a wrong limit or field slice would either write into a modelled core or miss the error pulse. Target failures are injected on reads and on writes, and a command is offered while busy; a design that drops the abort, or latches the second command, would produce a write or a stray doorbell.

// File: rtl/ipi_send_pkg.sv
package ipi_send_pkg;
  localparam int CORE_W = 10;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int VEC_W  = 5;
  localparam int OFS_W  = 9;

  localparam logic [OFS_W-1:0]  OFS_DOORBELL = 9'h040;
  localparam logic [OFS_W-1:0]  OFS_SLOT     = 9'h048;
  localparam logic [OFS_W-1:0]  OFS_FREE     = 9'h158;
  localparam logic [ADDR_W-1:0] SLOT_BASE    = 16'h1020;

  typedef enum logic [1:0] {K_NONE, K_BELL, K_SLOT, K_FREE} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_READ, S_MERGE, S_WRITE} state_e;

  typedef struct packed {
    kind_e              kind;
    logic [CORE_W-1:0]  core;
    logic [VEC_W-1:0]   vec;
    logic [ADDR_W-1:0]  addr;
    logic [LANES-1:0]   keep;
    logic [WORD_W-1:0]  payload;
  } cmd_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_send_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [63:0]      data,
  output cmd_t             dec,
  output logic             core_ok
);
  logic unused_bits;
  assign unused_bits = ^{data[31], data[26]};

  always_comb begin
    unique case (offset)
      OFS_DOORBELL: dec.kind = K_BELL;
      OFS_SLOT:     dec.kind = K_SLOT;
      OFS_FREE:     dec.kind = K_FREE;
      default:      dec.kind = K_NONE;
    endcase
    dec.core    = data[16 +: CORE_W];
    dec.vec     = data[VEC_W-1:0];
    dec.keep    = data[27 +: LANES];
    dec.payload = data[32 +: WORD_W];
    if (dec.kind == K_SLOT)
      dec.addr = SLOT_BASE + ADDR_W'({data[4:2], 2'b00});
    else
      dec.addr = data[ADDR_W-1:0];
  end

  assign core_ok = {1'b0, dec.core} < (CORE_W+1)'(NUM_CORES);
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge
  import ipi_send_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] payload,
  input  logic [LANES-1:0]  keep,
  output logic [WORD_W-1:0] merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[8*i +: 8] = keep[i] ? old_word[8*i +: 8] : payload[8*i +: 8];
  end
endmodule

// File: rtl/ipi_send_decoder.sv
module ipi_send_decoder
  import ipi_send_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [OFS_W-1:0]  cmd_offset,
  input  logic [63:0]       cmd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ipi_set_valid,
  output logic [CORE_W-1:0] ipi_set_core,
  output logic [VEC_W-1:0]  ipi_set_vec,
  output logic              bus_req,
  output logic              bus_we,
  output logic [CORE_W-1:0] bus_core,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err
);
  state_e            state;
  cmd_t              dec;
  logic              core_ok;
  logic [LANES-1:0]  keep_q;
  logic [WORD_W-1:0] pay_q;
  logic [WORD_W-1:0] old_q;
  logic [WORD_W-1:0] merged;

  ipi_cmd_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .offset (cmd_offset),
    .data   (cmd_data),
    .dec    (dec),
    .core_ok(core_ok)
  );

  ipi_byte_merge u_merge (
    .old_word(old_q),
    .payload (pay_q),
    .keep    (keep_q),
    .merged  (merged)
  );

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      done          <= 1'b0;
      err           <= 1'b0;
      ipi_set_valid <= 1'b0;
      ipi_set_core  <= '0;
      ipi_set_vec   <= '0;
      bus_req       <= 1'b0;
      bus_we        <= 1'b0;
      bus_core      <= '0;
      bus_addr      <= '0;
      bus_wdata     <= '0;
      keep_q        <= '0;
      pay_q         <= '0;
      old_q         <= '0;
    end else begin
      done          <= 1'b0;
      err           <= 1'b0;
      ipi_set_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_valid && dec.kind != K_NONE) begin
            if (!core_ok) begin
              err <= 1'b1;
            end else if (dec.kind == K_BELL) begin
              ipi_set_valid <= 1'b1;
              ipi_set_core  <= dec.core;
              ipi_set_vec   <= dec.vec;
              done          <= 1'b1;
            end else begin
              bus_core <= dec.core;
              bus_addr <= dec.addr;
              keep_q   <= dec.keep;
              pay_q    <= dec.payload;
              bus_req  <= 1'b1;
              if (dec.keep != '0) begin
                bus_we <= 1'b0;
                state  <= S_READ;
              end else begin
                bus_we    <= 1'b1;
                bus_wdata <= dec.payload;
                state     <= S_WRITE;
              end
            end
          end
        end
        S_READ: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            if (bus_err) begin
              err   <= 1'b1;
              state <= S_IDLE;
            end else begin
              old_q <= bus_rdata;
              state <= S_MERGE;
            end
          end
        end
        S_MERGE: begin
          bus_wdata <= merged;
          bus_we    <= 1'b1;
          bus_req   <= 1'b1;
          state     <= S_WRITE;
        end
        S_WRITE: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            state   <= S_IDLE;
            if (bus_err) err  <= 1'b1;
            else         done <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: a request only exists inside a busy sequence
  a_r8_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  // R8: request lines stay steady until acknowledged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_core)));

  // R9: a command ends with one response kind only
  a_r9_resp_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R1: doorbells reach present cores only
  a_r1_bell_core_present: assert property (@(posedge clk) disable iff (rst)
    ipi_set_valid |-> ({1'b0, ipi_set_core} < (CORE_W+1)'(NUM_CORES)));

  // R6: a read is only issued when some byte is kept
  a_r6_read_needs_keep: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |-> (keep_q != '0));

  // R7: the write after a read goes to the address that was read
  a_r7_write_same_addr: assert property (@(posedge clk) disable iff (rst)
    (state == S_MERGE) |=> (bus_req && bus_we && $stable(bus_addr)));
endmodule

// File: tb/ipi_send_decoder_bench.sv
module ipi_send_decoder_bench;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [8:0]  cmd_offset = '0;
  logic [63:0] cmd_data = '0;
  logic        busy, done, err, ipi_set_valid;
  logic [9:0]  ipi_set_core;
  logic [4:0]  ipi_set_vec;
  logic        bus_req, bus_we;
  logic [9:0]  bus_core;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;

  ipi_send_decoder #(.NUM_CORES(NC)) u_ipi_send_decoder (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_offset(cmd_offset),
    .cmd_data(cmd_data), .busy(busy), .done(done), .err(err),
    .ipi_set_valid(ipi_set_valid), .ipi_set_core(ipi_set_core),
    .ipi_set_vec(ipi_set_vec), .bus_req(bus_req), .bus_we(bus_we),
    .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
  );

  always #4 clk = ~clk;

  // target model: per core 64 words indexed by address bits 7..2
  logic [31:0] mem [0:3][0:63];
  logic        fail_rd = 1'b0, fail_wr = 1'b0;
  int          n_rd = 0, n_wr = 0;
  int          compared = 0, mismatched = 0;
  int          cycles = 0;
  logic        bell_seen = 1'b0;

  always @(posedge clk) begin
    if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        n_wr <= n_wr + 1;
        bus_err <= fail_wr;
        if (!fail_wr) mem[bus_core[1:0]][bus_addr[7:2]] <= bus_wdata;
      end else begin
        n_rd <= n_rd + 1;
        bus_err <= fail_rd;
        bus_rdata <= mem[bus_core[1:0]][bus_addr[7:2]];
      end
    end else begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
    end
    if (ipi_set_valid) bell_seen <= 1'b1;
    cycles <= cycles + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] blend(input logic [31:0] o, input logic [31:0] p, input logic [3:0] k);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{k[i]}};
    return (o & m) | (p & ~m);
  endfunction

  // issues one command, waits for a response; resp 1 = done, 2 = err, 0 = none
  task automatic issue(input logic [8:0] ofs, input logic [63:0] d, output int resp);
    int n;
    @(negedge clk);
    n_rd = 0; n_wr = 0; bell_seen = 1'b0;
    cmd_valid = 1'b1; cmd_offset = ofs; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!(done || err) && n < 40) begin
      @(negedge clk);
      n++;
    end
    resp = done ? 1 : (err ? 2 : 0);
  endtask

  task automatic post(input logic [8:0] ofs, input int core, input logic [15:0] low,
                      input logic [3:0] keep, input logic [31:0] pay, input string tag);
    int resp;
    logic [15:0] addr;
    logic [31:0] old, exp;
    logic [63:0] d;
    addr = (ofs == 9'h048) ? 16'h1020 + {11'd0, low[4:2], 2'b00} : low;
    old = mem[core[1:0]][addr[7:2]];
    d = {pay, 1'b0, keep, 1'b0, 10'(core), low};
    issue(ofs, d, resp);
    if (core >= NC) begin
      chk(resp == 2, {"R1 absent core err ", tag}, resp, 2);
      chk(n_rd == 0 && n_wr == 0, {"R1 no bus access ", tag}, n_rd + n_wr, 0);
      chk(mem[core[1:0]][addr[7:2]] == old, {"R1 word untouched ", tag}, mem[core[1:0]][addr[7:2]], old);
    end else begin
      exp = blend(old, pay, keep);
      chk(resp == 1, {"R3/R4 done ", tag}, resp, 1);
      chk(mem[core[1:0]][addr[7:2]] == exp, {"R5 merged word ", tag}, mem[core[1:0]][addr[7:2]], exp);
      if (keep == 4'h0) chk(n_rd == 0 && n_wr == 1, {"R6 single write ", tag}, n_rd * 16 + n_wr, 1);
      else              chk(n_rd == 1 && n_wr == 1, {"R7 read then write ", tag}, n_rd * 16 + n_wr, 17);
    end
  endtask

  initial begin
    int resp;
    logic [31:0] seed;
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 64; w++) mem[c][w] = 32'h9E37_79B9 * (c * 64 + w + 1);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !bus_req && !ipi_set_valid, "R11 reset state",
        {busy, done, err, bus_req, ipi_set_valid}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 doorbells: every vector, present cores; plus absent cores (R1)
    for (int c = 0; c < NC + 1; c++)
      for (int v = 0; v < 32; v++) begin
        @(negedge clk);
        bell_seen = 1'b0;
        cmd_valid = 1'b1; cmd_offset = 9'h040;
        cmd_data = {32'hFFFF_FFFF, 6'd0, 10'(c), 11'h7FF, 5'(v)};
        @(negedge clk);
        cmd_valid = 1'b0;
        if (c < NC) begin
          chk(done && ipi_set_valid && ipi_set_core == 10'(c) && ipi_set_vec == 5'(v),
              "R2 doorbell", {ipi_set_valid, ipi_set_core, ipi_set_vec}, {1'b1, 10'(c), 5'(v)});
        end else begin
          chk(err && !done && !ipi_set_valid, "R1 absent doorbell", {err, done, ipi_set_valid}, 3'b100);
        end
      end
    @(negedge clk);
    issue(9'h040, {32'd0, 6'd0, 10'h3FF, 16'd3}, resp);
    chk(resp == 2 && !bell_seen, "R1 core 1023 doorbell", resp, 2);

    // R3 mailbox sweep: every slot x every keep mask
    seed = 32'h1234_5678;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 16; k++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          post(9'h048, c, 16'(s * 4) | 16'hFF00, 4'(k), seed, "slot");
        end

    // R4 free-address sweep
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < 6; a++)
        for (int k = 0; k < 16; k++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          post(9'h158, c, 16'h1100 + 16'(a * 4 * 7), 4'(k), seed, "free");
        end

    // R1 absent cores on posting commands
    post(9'h048, NC, 16'd8, 4'h5, 32'hDEAD_BEEF, "slot absent");
    post(9'h158, 1023, 16'h1104, 4'h0, 32'hDEAD_BEEF, "free absent");

    // R9 read failure: err, no write
    begin
      logic [31:0] old;
      old = mem[1][9];
      fail_rd = 1'b1;
      issue(9'h048, {32'hAAAA_5555, 1'b0, 4'hF, 1'b0, 10'd1, 16'd4}, resp);
      fail_rd = 1'b0;
      chk(resp == 2, "R9 read failure err", resp, 2);
      chk(n_wr == 0 && mem[1][9] == old, "R9 no write after failed read", n_wr, 0);
      old = mem[2][10];
      fail_wr = 1'b1;
      issue(9'h048, {32'h1111_2222, 1'b0, 4'h0, 1'b0, 10'd2, 16'd8}, resp);
      fail_wr = 1'b0;
      chk(resp == 2 && mem[2][10] == old, "R9 write failure err", resp, 2);
    end

    // R8 command while busy is ignored
    @(negedge clk);
    bell_seen = 1'b0;
    cmd_valid = 1'b1; cmd_offset = 9'h048; cmd_data = {32'h0F0F_0F0F, 1'b0, 4'h3, 1'b0, 10'd0, 16'd0};
    @(negedge clk);
    cmd_offset = 9'h040; cmd_data = {32'd0, 6'd0, 10'd1, 16'd7};
    chk(busy == 1'b1, "R8 busy during sequence", busy, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(!bell_seen && !busy, "R8 command while busy ignored", bell_seen, 0);

    // R10 unknown offsets
    foreach (seed[i]) begin
      if (i < 4) begin
        logic [8:0] ofs;
        ofs = (i == 0) ? 9'h000 : (i == 1) ? 9'h004 : (i == 2) ? 9'h00C : 9'h020;
        @(negedge clk);
        bell_seen = 1'b0; n_rd = 0; n_wr = 0;
        cmd_valid = 1'b1; cmd_offset = ofs; cmd_data = {32'h1234_5678, 1'b0, 4'h0, 1'b0, 10'd0, 16'h1020};
        @(negedge clk);
        cmd_valid = 1'b0;
        resp = 0;
        for (int j = 0; j < 6; j++) begin
          if (done || err || bus_req || busy) resp = 1;
          @(negedge clk);
        end
        chk(resp == 0 && !bell_seen && n_wr == 0 && n_rd == 0, "R10 unknown offset ignored", resp, 0);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule